// File: doc/BRIEF.md
# Configuration Scan Path for a Test Access Port

This block forms the data-register half of a boundary test port on a device whose operating settings come from a serial configuration word. A separate TAP state machine supplies one-hot state strobes: Test-Logic-Reset, the three instruction-register states and the three data-register states. From these strobes the block keeps a 4-bit instruction register. It decides which data register sits between `tdi` and `tdo`: a 1-bit bypass stage, a 32-bit identification word, or a 112-bit programming chain. It then carries out capture, shift and update on that register.

The programming chain holds 96 writable configuration bits nearest the output, followed by 16 read-only reserved positions. A program-write scan commits the first 96 positions to a volatile settings register on Update-DR. A program-read scan captures that register, together with a fixed reserved pattern, so it can be shifted out. A separate save/restore engine drives `busy`. While `busy` is high, every programming instruction falls back to the bypass stage and commits nothing. The block gives the engine a one-cycle start pulse when it accepts a save or restore instruction. `tdo` is launched on the falling edge of `tck`.

Top module: `cfgScanPath`

## Requirements
- R1: An active-low `trstN`, or a clock edge with `tlrState` high, loads IDCODE (4'h2) into the instruction register. `trstN` also clears `cfgOut` to zero. The first data scan after either event shifts out the identification word, LSB first, with its bit 0 forced to 1.
- R2: The instruction register is 4 bits and shifts in at its MSB, so opcode bit 0 is sent first. Capture-IR loads 4'b0001, and this value appears on `tdo` LSB first. The opcodes are: EXTEST 4'h0, SAMPLE 4'h1, IDCODE 4'h2, CLAMP 4'h4, HIGHZ 4'h5, PWRITE 4'h8, PREAD 4'h9, PSAVE 4'hA, PRESTORE 4'hB, BYPASS 4'hF.
- R3: BYPASS, CLAMP, HIGHZ, SAMPLE, EXTEST, PSAVE, PRESTORE and every unlisted opcode select the 1-bit bypass stage. That stage captures 0.
- R4: Under PWRITE the path is 112 bits long, and position 0 is next to `tdo`. After 112 shifts, configuration bit k equals the k-th bit shifted in, counting from 0. Update-DR copies bits 0..95 to `cfgOut`. `cfgOut` changes at no other time, apart from reset.
- R5: Under PREAD, Capture-DR loads `cfgOut` into positions 0..95 and the reserved pattern into positions 96..111. Configuration bit 0 is the first bit on `tdo`. Update-DR under PREAD leaves `cfgOut` unchanged.
- R6: The 16 reserved positions are read-only. Whatever padding a write shifts into them, the next read returns the reserved pattern (default 16'h5A3C).
- R7: If `busy` is high at the Update-IR edge and the shifted opcode is PWRITE, PREAD, PSAVE or PRESTORE, the instruction register loads BYPASS instead, and no start pulse is issued. The bypass path then stays in place after `busy` falls.
- R8: While `busy` is high, an already active PWRITE or PREAD selects the bypass stage, and Update-DR does not change `cfgOut`.
- R9: Instructions other than PWRITE, PREAD, PSAVE and PRESTORE decode normally while `busy` is high. For example, IDCODE still shifts out the identification word.
- R10: When Update-IR accepts PSAVE with `busy` low, `saveStart` is high for exactly the one cycle after that edge. PRESTORE raises `restoreStart` in the same way. The two pulses never coincide.
- R11: `tdo` and `tdoEn` change on the falling edge of `tck`. `tdoEn` is high only while Shift-DR or Shift-IR is active, and `tdo` is 0 when `tdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tlrState | input | 1 | TAP is in Test-Logic-Reset |
| captureIr | input | 1 | TAP is in Capture-IR |
| shiftIr | input | 1 | TAP is in Shift-IR |
| updateIr | input | 1 | TAP is in Update-IR |
| captureDr | input | 1 | TAP is in Capture-DR |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| busy | input | 1 | Save/restore engine is running |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| tdoEn | output | 1 | Output enable for `tdo` |
| cfgOut | output | 96 | Volatile configuration settings |
| saveStart | output | 1 | One-cycle request to copy the settings to storage |
| restoreStart | output | 1 | One-cycle request to reload the settings from storage |

## Verification
The assertions assume that at most one of the state strobes is high in any cycle. They also assume that the strobes and `busy` change only just after a rising `tck` edge, as a real TAP controller and engine would drive them. The bench changes every input one time unit after the rising edge. It follows only legal TAP paths: capture, then shifts, then an exit cycle, then update. It raises `busy` only between scans, apart from one directed case where `busy` rises under an active PWRITE. It samples `tdo` just after the falling edge.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'h2;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'h4;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'h5;
  localparam logic [IR_W-1:0] OP_PWRITE   = 4'h8;
  localparam logic [IR_W-1:0] OP_PREAD    = 4'h9;
  localparam logic [IR_W-1:0] OP_PSAVE    = 4'hA;
  localparam logic [IR_W-1:0] OP_PRESTORE = 4'hB;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;

  typedef enum logic [1:0] {
    PATH_BYP  = 2'd0,
    PATH_ID   = 2'd1,
    PATH_PROG = 2'd2
  } path_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    path_e path;
    logic  capture;
    logic  shift;
    logic  commit;
  } drStrobe_t;

  // Programming opcodes occupy 4'b10xx
  function automatic logic isProgOp(input logic [IR_W-1:0] op);
    return op[IR_W-1:IR_W-2] == 2'b10;
  endfunction

endpackage

// File: rtl/cfgScanShiftReg.sv
module cfgScanShiftReg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] capVal,
  output logic [W-1:0] q
);

  logic [W-1:0] shiftNext;

  generate
    if (W == 1) begin : g_single
      assign shiftNext = tdi;
    end else begin : g_multi
      assign shiftNext = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      q <= '0;
    end else if (sel && capture) begin
      q <= capVal;
    end else if (sel && shift) begin
      q <= shiftNext;
    end
  end

endmodule

// File: rtl/cfgScanCtrl.sv
module cfgScanCtrl
  import cfgscan_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tlrState,
  input  logic      captureIr,
  input  logic      shiftIr,
  input  logic      updateIr,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  input  logic      tdi,
  input  logic      busy,
  output drStrobe_t drCtl,
  output logic      irTdo,
  output logic      saveStart,
  output logic      restoreStart
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] instr;
  logic            acceptIr;
  path_e           pathSel;

  // Programming opcodes are refused while the engine runs
  assign acceptIr = updateIr && !tlrState && !(busy && isProgOp(irShift));

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
    end else if (captureIr) begin
      irShift <= IR_CAPTURE;
    end else if (shiftIr) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      instr <= OP_IDCODE;
    end else if (tlrState) begin
      instr <= OP_IDCODE;
    end else if (updateIr) begin
      instr <= acceptIr ? irShift : OP_BYPASS;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      saveStart    <= 1'b0;
      restoreStart <= 1'b0;
    end else begin
      saveStart    <= acceptIr && (irShift == OP_PSAVE);
      restoreStart <= acceptIr && (irShift == OP_PRESTORE);
    end
  end

  always_comb begin
    unique case (instr)
      OP_IDCODE:          pathSel = PATH_ID;
      OP_PWRITE, OP_PREAD: pathSel = PATH_PROG;
      default:            pathSel = PATH_BYP;
    endcase
    if (busy && isProgOp(instr)) begin
      pathSel = PATH_BYP;
    end
  end

  always_comb begin
    drCtl.path    = pathSel;
    drCtl.capture = captureDr;
    drCtl.shift   = shiftDr;
    drCtl.commit  = updateDr && !busy && (instr == OP_PWRITE);
  end

  assign irTdo = irShift[0];

endmodule

// File: rtl/cfgScanData.sv
module cfgScanData
  import cfgscan_pkg::*;
#(
  parameter int              CFG_BITS  = 96,
  parameter int              RSV_BITS  = 16,
  parameter logic [RSV_BITS-1:0] RSV_VALUE = 16'h5A3C,
  parameter int              ID_BITS   = 32,
  parameter logic [ID_BITS-1:0]  ID_VALUE  = 32'h0C3A_5E17
) (
  input  logic                tck,
  input  logic                trstN,
  input  drStrobe_t           drCtl,
  input  logic                tdi,
  output logic                drTdo,
  output logic [CFG_BITS-1:0] cfgOut
);

  localparam int CHAIN_BITS = CFG_BITS + RSV_BITS;
  localparam logic [ID_BITS-1:0] ID_CAPTURE = {ID_VALUE[ID_BITS-1:1], 1'b1};

  logic [0:0]            bypassQ;
  logic [ID_BITS-1:0]    idQ;
  logic [CHAIN_BITS-1:0] chainQ;
  logic [CFG_BITS-1:0]   cfgQ;

  cfgScanShiftReg #(.W(1)) u_bypass (
    .tck     (tck),
    .trstN   (trstN),
    .sel     (drCtl.path == PATH_BYP),
    .capture (drCtl.capture),
    .shift   (drCtl.shift),
    .tdi     (tdi),
    .capVal  (1'b0),
    .q       (bypassQ)
  );

  cfgScanShiftReg #(.W(ID_BITS)) u_ident (
    .tck     (tck),
    .trstN   (trstN),
    .sel     (drCtl.path == PATH_ID),
    .capture (drCtl.capture),
    .shift   (drCtl.shift),
    .tdi     (tdi),
    .capVal  (ID_CAPTURE),
    .q       (idQ)
  );

  cfgScanShiftReg #(.W(CHAIN_BITS)) u_chain (
    .tck     (tck),
    .trstN   (trstN),
    .sel     (drCtl.path == PATH_PROG),
    .capture (drCtl.capture),
    .shift   (drCtl.shift),
    .tdi     (tdi),
    .capVal  ({RSV_VALUE, cfgQ}),
    .q       (chainQ)
  );

  // Only the writable part of the chain reaches the settings register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      cfgQ <= '0;
    end else if (drCtl.commit) begin
      cfgQ <= chainQ[CFG_BITS-1:0];
    end
  end

  always_comb begin
    unique case (drCtl.path)
      PATH_ID:   drTdo = idQ[0];
      PATH_PROG: drTdo = chainQ[0];
      default:   drTdo = bypassQ[0];
    endcase
  end

  assign cfgOut = cfgQ;

endmodule

// File: rtl/cfgScanPath.sv
module cfgScanPath
  import cfgscan_pkg::*;
#(
  parameter int              CFG_BITS  = 96,
  parameter int              RSV_BITS  = 16,
  parameter logic [RSV_BITS-1:0] RSV_VALUE = 16'h5A3C,
  parameter int              ID_BITS   = 32,
  parameter logic [ID_BITS-1:0]  ID_VALUE  = 32'h0C3A_5E17
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tlrState,
  input  logic                captureIr,
  input  logic                shiftIr,
  input  logic                updateIr,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  input  logic                busy,
  output logic                tdo,
  output logic                tdoEn,
  output logic [CFG_BITS-1:0] cfgOut,
  output logic                saveStart,
  output logic                restoreStart
);

  drStrobe_t drCtl;
  logic      irTdo;
  logic      drTdo;

  cfgScanCtrl u_ctrl (
    .tck          (tck),
    .trstN        (trstN),
    .tlrState     (tlrState),
    .captureIr    (captureIr),
    .shiftIr      (shiftIr),
    .updateIr     (updateIr),
    .captureDr    (captureDr),
    .shiftDr      (shiftDr),
    .updateDr     (updateDr),
    .tdi          (tdi),
    .busy         (busy),
    .drCtl        (drCtl),
    .irTdo        (irTdo),
    .saveStart    (saveStart),
    .restoreStart (restoreStart)
  );

  cfgScanData #(
    .CFG_BITS  (CFG_BITS),
    .RSV_BITS  (RSV_BITS),
    .RSV_VALUE (RSV_VALUE),
    .ID_BITS   (ID_BITS),
    .ID_VALUE  (ID_VALUE)
  ) u_data (
    .tck    (tck),
    .trstN  (trstN),
    .drCtl  (drCtl),
    .tdi    (tdi),
    .drTdo  (drTdo),
    .cfgOut (cfgOut)
  );

  // Output is launched half a cycle after the shift edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= shiftIr || shiftDr;
      tdo   <= shiftIr ? irTdo : (shiftDr ? drTdo : 1'b0);
    end
  end

endmodule

// File: rtl/cfgScanPath_chk.sv
module cfgScanPath_chk #(
  parameter int CFG_BITS = 96
) (
  input logic                tck,
  input logic                trstN,
  input logic                shiftIr,
  input logic                shiftDr,
  input logic                updateIr,
  input logic                updateDr,
  input logic                busy,
  input logic                tdo,
  input logic                tdoEn,
  input logic [CFG_BITS-1:0] cfgOut,
  input logic                saveStart,
  input logic                restoreStart
);

  // R11: enable only while a shift state is active, output quiet otherwise
  p_tdoen_in_shift_r11: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (shiftIr || shiftDr));

  p_tdo_quiet_r11: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo);

  // R4: settings move only on an Update-DR edge
  p_cfg_hold_noupdate_r4: assert property (@(posedge tck) disable iff (!trstN)
    !$past(updateDr) |-> $stable(cfgOut));

  // R8: nothing commits while the engine runs
  p_cfg_hold_busy_r8: assert property (@(posedge tck) disable iff (!trstN)
    $past(busy) |-> $stable(cfgOut));

  // R10, R7: a start pulse follows an accepted Update-IR, never under busy
  p_save_accept_r10: assert property (@(posedge tck) disable iff (!trstN)
    saveStart |-> ($past(updateIr) && !$past(busy)));

  p_restore_accept_r10: assert property (@(posedge tck) disable iff (!trstN)
    restoreStart |-> ($past(updateIr) && !$past(busy)));

  p_start_excl_r10: assert property (@(posedge tck) disable iff (!trstN)
    !(saveStart && restoreStart));

  p_start_single_r10: assert property (@(posedge tck) disable iff (!trstN)
    saveStart |=> !saveStart);

endmodule

bind cfgScanPath cfgScanPath_chk #(.CFG_BITS(CFG_BITS)) u_chk (
  .tck          (tck),
  .trstN        (trstN),
  .shiftIr      (shiftIr),
  .shiftDr      (shiftDr),
  .updateIr     (updateIr),
  .updateDr     (updateDr),
  .busy         (busy),
  .tdo          (tdo),
  .tdoEn        (tdoEn),
  .cfgOut       (cfgOut),
  .saveStart    (saveStart),
  .restoreStart (restoreStart)
);

// File: tb/cfgScanPath_tb.sv
module cfgScanPath_tb;

  localparam logic [31:0] ID_WORD  = 32'h0C3A_5E17;
  localparam logic [15:0] RSV_WORD = 16'h5A3C;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tlrState = 0, captureIr = 0, shiftIr = 0, updateIr = 0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, tdi = 0, busy = 0;
  logic tdo, tdoEn, saveStart, restoreStart;
  logic [95:0] cfgOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int unsigned seed = 32'd20240611;

  always #2 tck = ~tck;

  cfgScanPath u_dut (
    .tck(tck), .trstN(trstN), .tlrState(tlrState), .captureIr(captureIr),
    .shiftIr(shiftIr), .updateIr(updateIr), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .busy(busy),
    .tdo(tdo), .tdoEn(tdoEn), .cfgOut(cfgOut), .saveStart(saveStart),
    .restoreStart(restoreStart)
  );

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] rand160();
    logic [159:0] v;
    for (int i = 0; i < 5; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  // Expected serial output of a path of length len that captured cap
  function automatic logic [159:0] expScan(input logic [159:0] cap, input int len,
                                           input logic [159:0] din, input int n);
    logic [159:0] v;
    logic [159:0] m;
    m = (n >= 160) ? '1 : ((160'd1 << n) - 160'd1);
    v = (cap & ((160'd1 << len) - 160'd1)) | (din << len);
    return v & m;
  endfunction

  // One TAP cycle: inputs set after the rising edge, tdo read after the falling edge
  task automatic step(input logic cI, sI, uI, cD, sD, uD, tl, d,
                      output logic outBit, output logic outEn);
    captureIr = cI; shiftIr = sI; updateIr = uI;
    captureDr = cD; shiftDr = sD; updateDr = uD; tlrState = tl; tdi = d;
    @(negedge tck); #1;
    outBit = tdo; outEn = tdoEn;
    @(posedge tck); #1;
  endtask

  task automatic idle(output logic outEn);
    logic b;
    step(0,0,0,0,0,0,0,0, b, outEn);
  endtask

  task automatic scanIr(input logic [3:0] op, output logic [3:0] capOut,
                        output logic sPulse, output logic rPulse, output logic later);
    logic e;
    logic b;
    step(1,0,0,0,0,0,0,0, b, e);
    for (int i = 0; i < 4; i++) begin
      step(0,1,0,0,0,0,0,op[i], b, e);
      capOut[i] = b;
    end
    idle(e);
    step(0,0,1,0,0,0,0,0, b, e);
    sPulse = saveStart; rPulse = restoreStart;
    idle(e);
    later = saveStart | restoreStart;
  endtask

  task automatic loadIr(input logic [3:0] op);
    logic [3:0] c;
    logic s, r, l;
    scanIr(op, c, s, r, l);
  endtask

  task automatic scanDr(input int n, input logic [159:0] din, output logic [159:0] dout);
    logic e;
    logic b;
    dout = '0;
    step(0,0,0,1,0,0,0,0, b, e);
    for (int i = 0; i < n; i++) begin
      step(0,0,0,0,1,0,0,din[i], b, e);
      dout[i] = b;
    end
    idle(e);
    step(0,0,0,0,0,1,0,0, b, e);
    idle(e);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [159:0] din, dout, exp;
    logic [95:0] model, saved;
    logic [3:0] cap;
    logic s, r, l, e;
    logic [3:0] bypList [8];

    void'($urandom(seed));
    model = '0;
    repeat (3) @(posedge tck);
    #1 trstN = 1'b1;
    @(posedge tck); #1;

    // R1 / R11: reset state
    idle(e);
    check(e == 1'b0, "R11 tdoEn idle", e, 0);
    check(cfgOut == '0, "R1 cfgOut reset", cfgOut, 0);
    din = rand160();
    scanDr(40, din, dout);
    exp = expScan({128'd0, ID_WORD | 32'd1}, 32, din, 40);
    check(dout == exp, "R1 idcode after reset", dout, exp);

    // R2: capture pattern on the instruction path
    scanIr(4'hF, cap, s, r, l);
    check(cap == 4'b0001, "R2 IR capture", cap, 4'b0001);

    // R3: opcodes that land on the bypass stage
    bypList = '{4'hF, 4'h4, 4'h5, 4'h1, 4'h0, 4'h7, 4'hC, 4'h3};
    foreach (bypList[k]) begin
      loadIr(bypList[k]);
      din = rand160();
      scanDr(24, din, dout);
      exp = expScan('0, 1, din, 24);
      check(dout == exp, "R3 bypass path", dout, exp);
    end

    // R4 / R5 / R6: random write then read rounds
    for (int round = 0; round < 12; round++) begin
      din = rand160();
      loadIr(4'h8);
      scanDr(112, din, dout);
      model = din[95:0];
      check(cfgOut == model, "R4 write commit", cfgOut, model);
      loadIr(4'h9);
      din = rand160();
      scanDr(112, din, dout);
      exp = expScan({48'd0, RSV_WORD, model}, 112, din, 112);
      check(dout == exp, "R5 R6 read capture", dout, exp);
      check(cfgOut == model, "R5 read no commit", cfgOut, model);
    end

    // R4: a read that overruns the chain shows the incoming bits after 112 shifts
    din = rand160();
    scanDr(140, din, dout);
    exp = expScan({48'd0, RSV_WORD, model}, 112, din, 140);
    check(dout == exp, "R4 chain length", dout, exp);

    // R8: busy rises under an active write
    loadIr(4'h8);
    busy = 1'b1;
    saved = cfgOut;
    din = rand160();
    scanDr(30, din, dout);
    exp = expScan('0, 1, din, 30);
    check(dout == exp, "R8 busy bypass", dout, exp);
    check(cfgOut == saved, "R8 no commit while busy", cfgOut, saved);
    busy = 1'b0;
    din = rand160();
    scanDr(112, din, dout);
    model = din[95:0];
    check(cfgOut == model, "R8 write resumes", cfgOut, model);

    // R7: programming opcode refused while busy, stays bypass afterwards
    busy = 1'b1;
    loadIr(4'h9);
    busy = 1'b0;
    din = rand160();
    scanDr(30, din, dout);
    exp = expScan('0, 1, din, 30);
    check(dout == exp, "R7 refused read", dout, exp);
    busy = 1'b1;
    scanIr(4'hA, cap, s, r, l);
    check({s, r} == 2'b00, "R7 save refused", {s, r}, 0);

    // R9: identification works while busy
    loadIr(4'h2);
    din = rand160();
    scanDr(36, din, dout);
    exp = expScan({128'd0, ID_WORD | 32'd1}, 32, din, 36);
    check(dout == exp, "R9 idcode busy", dout, exp);
    busy = 1'b0;

    // R10: start pulses
    scanIr(4'hA, cap, s, r, l);
    check({s, r, l} == 3'b100, "R10 save pulse", {s, r, l}, 3'b100);
    din = rand160();
    scanDr(20, din, dout);
    exp = expScan('0, 1, din, 20);
    check(dout == exp, "R3 save on bypass", dout, exp);
    scanIr(4'hB, cap, s, r, l);
    check({s, r, l} == 3'b010, "R10 restore pulse", {s, r, l}, 3'b010);

    // R1: Test-Logic-Reset returns to identification
    loadIr(4'h8);
    step(0,0,0,0,0,0,1,0, s, e);
    din = rand160();
    scanDr(32, din, dout);
    exp = expScan({128'd0, ID_WORD | 32'd1}, 32, din, 32);
    check(dout == exp, "R1 tlr idcode", dout, exp);
    check(cfgOut == model, "R1 tlr keeps cfg", cfgOut, model);

    // R11: tdo launched on the falling edge; quiet after shift ends
    idle(e);
    check({e, tdo} == 2'b00, "R11 quiet after shift", {e, tdo}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule